// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader with Read-Back Verify

This block brings a chip's internal memory and registers up from an external serial EEPROM. A one-cycle `start` pulse begins a run. The block opens an SPI read frame and streams the whole configuration image into the memory write port, one byte per address. It then closes the frame and opens a second read frame over the same EEPROM range. Each byte from the second frame is compared with what the memory port returns for the same address. The last byte of the image is a checksum. It must equal the 8-bit wrapping sum of all the bytes before it.

Two fault kinds are kept apart. A read-back mismatch sets the compare flag and stops the verify pass at once. The address of that first bad location is kept as a low capture byte and a high capture byte. A checksum mismatch sets a separate flag. Either flag drives the interrupt line, which the surrounding sequencer uses to hold the chip in a safe state. No mask can hide these flags. They stay set until the next `start`. `done` pulses once at the end of every run, whatever the outcome.

Top module: `eeld_autoload`

## Requirements
- R1: A `start` pulse while idle sets `busy` on the next edge. `busy` stays high for the whole run. `done` is high for exactly one cycle per run, and `busy` is low from the cycle after that.
- R2: SPI runs in mode 0. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` is set up while the clock is low, and `spi_miso` is sampled on the rising clock edge, most significant bit first.
- R3: Each chip-select frame begins with the read command byte 0x03. Next come the 16-bit EEPROM start address `EE_BASE`, high byte first, and then sequential data bytes.
- R4: In the load pass, data byte j of the first frame is written to memory address j, for j = 0 to IMG_BYTES-1. `mem_we` and `mem_re` are never high in the same cycle.
- R5: `sum_err` is set when the image's final byte differs from the modulo-256 sum of all the image's earlier bytes.
- R6: After the load frame ends, a second frame reads the image again. For each byte, `mem_re` is raised for one cycle and `mem_rdata` is taken on the following cycle. Any difference from the EEPROM byte sets `cmp_err`.
- R7: The verify pass stops at the first mismatch. The mismatching memory address is kept, with bits 7:0 in `fail_lo` and bits 15:8 in `fail_hi`. Later bytes are not examined.
- R8: `irq` is high exactly when `cmp_err` or `sum_err` is set. Both flags and both capture bytes are cleared when a run starts, and they hold their values while idle.
- R9: After reset, `spi_cs_n` is high, `spi_sclk`, `busy`, `done`, `irq`, `mem_we` and `mem_re` are low, and the flags and capture bytes are zero.
- R10: A `start` pulse during a run is ignored. It adds no frame and no `done` pulse, and it does not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a load-and-verify run |
| done | output | 1 | One-cycle pulse when a run ends |
| busy | output | 1 | High while a run is in progress |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| cmp_err | output | 1 | Read-back compare mismatch flag |
| sum_err | output | 1 | Checksum mismatch flag |
| fail_lo | output | 8 | First mismatching address, bits 7:0 |
| fail_hi | output | 8 | First mismatching address, bits 15:8 |
| irq | output | 1 | Master interrupt, either flag set |

## Verification
The bench's memory model can make chosen locations read back with a flipped bit. This covers a fault at address 0, at the last image byte, and above address 255. A design that splits the capture wrongly, or lets the high byte go, shows the wrong `fail_hi` there. Two faults in one image show whether the lower address is kept. A design that keeps comparing would report the later one. Images with a bad checksum, alone and together with a compare fault, show whether the two flags are kept apart. A clean run after a failing one shows whether flags are cleared at `start`. A second `start` sent mid-run would show up as an extra frame or an extra `done` in a design that fails to ignore it. The EEPROM model decodes the command and address bits of each frame. A wrong SPI bit order or clock edge therefore gives a bad header or wrong data.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

  localparam logic [7:0] EE_READ_OP = 8'h03;
  localparam logic [7:0] EE_DUMMY   = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LHDR,
    S_LDAT,
    S_GAP,
    S_VHDR,
    S_VDAT,
    S_VRD,
    S_VCMP,
    S_DONE
  } seq_state_e;

  typedef struct packed {
    logic        cmp_err;
    logic        sum_err;
    logic [15:0] fail_addr;
  } verify_res_t;

endpackage

// File: rtl/eeld_spi_byte.sv
module eeld_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          act_q, act_d;
  logic          sclk_q, sclk_d;
  logic          mosi_q, mosi_d;
  logic          done_q, done_d;
  logic          tick;
  logic          en;

  assign tick = act_q && (cnt_q == CNT_END);
  assign en   = act_q || start || done_q;

  always_comb begin
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    act_d  = act_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        sh_d   = tx;
        mosi_d = tx[7];
        bit_d  = 3'd0;
        cnt_d  = '0;
        sclk_d = 1'b0;
      end
    end else begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
      if (tick) begin
        if (!sclk_q) begin
          // rising edge: sample the slave's bit
          sclk_d = 1'b1;
          sh_d   = {sh_q[6:0], miso};
        end else begin
          // falling edge: next bit or end of byte
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d  = bit_q + 3'd1;
            mosi_d = sh_q[7];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= 3'd0;
      sh_q   <= 8'h00;
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      act_q  <= act_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = mosi_q;
  assign done = done_q;
  assign rx   = sh_q;

endmodule

// File: rtl/eeld_seq.sv
module eeld_seq
  import eeld_pkg::*;
#(
  parameter int          IMG_BYTES = 16,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] EE_BASE   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              x_done,
  input  logic [7:0]        x_rx,
  output logic              x_start,
  output logic [7:0]        x_tx,
  output logic              cs_n,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic              busy,
  output verify_res_t       res
);

  localparam int IDX_W = (IMG_BYTES > 2) ? $clog2(IMG_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_BYTES - 1);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       hdr_q, hdr_d;
  logic [7:0]       sum_q, sum_d;
  logic [7:0]       vb_q, vb_d;
  verify_res_t      res_q, res_d;

  function automatic logic [7:0] hdr_byte(input logic [1:0] n);
    case (n)
      2'd0:    hdr_byte = EE_BASE[15:8];
      2'd1:    hdr_byte = EE_BASE[7:0];
      default: hdr_byte = EE_DUMMY;
    endcase
  endfunction

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    hdr_d   = hdr_q;
    sum_d   = sum_q;
    vb_d    = vb_q;
    res_d   = res_q;
    x_start = 1'b0;
    x_tx    = EE_READ_OP;
    mem_we  = 1'b0;
    mem_re  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          res_d   = '0;
          idx_d   = '0;
          hdr_d   = 2'd0;
          sum_d   = 8'h00;
          x_start = 1'b1;
          st_d    = S_LHDR;
        end
      end
      S_LHDR, S_VHDR: begin
        if (x_done) begin
          x_start = 1'b1;
          x_tx    = hdr_byte(hdr_q);
          if (hdr_q == 2'd2) begin
            st_d = (st_q == S_LHDR) ? S_LDAT : S_VDAT;
          end else begin
            hdr_d = hdr_q + 2'd1;
          end
        end
      end
      S_LDAT: begin
        if (x_done) begin
          mem_we = 1'b1;
          if (idx_q == LAST_IDX) begin
            res_d.sum_err = (x_rx != sum_q);
            st_d          = S_GAP;
          end else begin
            sum_d   = sum_q + x_rx;
            idx_d   = idx_q + 1'b1;
            x_start = 1'b1;
            x_tx    = EE_DUMMY;
          end
        end
      end
      S_GAP: begin
        idx_d   = '0;
        hdr_d   = 2'd0;
        x_start = 1'b1;
        st_d    = S_VHDR;
      end
      S_VDAT: begin
        if (x_done) begin
          vb_d = x_rx;
          st_d = S_VRD;
        end
      end
      S_VRD: begin
        mem_re = 1'b1;
        st_d   = S_VCMP;
      end
      S_VCMP: begin
        if (mem_rdata != vb_q) begin
          res_d.cmp_err   = 1'b1;
          res_d.fail_addr = 16'(idx_q);
          st_d            = S_DONE;
        end else if (idx_q == LAST_IDX) begin
          st_d = S_DONE;
        end else begin
          idx_d   = idx_q + 1'b1;
          x_start = 1'b1;
          x_tx    = EE_DUMMY;
          st_d    = S_VDAT;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      hdr_q <= 2'd0;
      sum_q <= 8'h00;
      vb_q  <= 8'h00;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      hdr_q <= hdr_d;
      sum_q <= sum_d;
      vb_q  <= vb_d;
      res_q <= res_d;
    end
  end

  assign cs_n      = (st_q == S_IDLE) || (st_q == S_GAP) || (st_q == S_DONE);
  assign mem_addr  = ADDR_W'(idx_q);
  assign mem_wdata = x_rx;
  assign done      = (st_q == S_DONE);
  assign busy      = (st_q != S_IDLE);
  assign res       = res_q;

endmodule

// File: rtl/eeld_autoload.sv
module eeld_autoload
  import eeld_pkg::*;
#(
  parameter int          IMG_BYTES = 16,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] EE_BASE   = 16'h0000,
  parameter int          SCLK_HALF = 2,
  parameter int          RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              busy,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              cmp_err,
  output logic              sum_err,
  output logic [7:0]        fail_lo,
  output logic [7:0]        fail_hi,
  output logic              irq
);

  logic [RST_SYNC-1:0] rsync_q;
  logic                rst_int_n;
  logic                x_start, x_done;
  logic [7:0]          x_tx, x_rx;
  verify_res_t         res;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[RST_SYNC-1];

  eeld_spi_byte #(.HALF(SCLK_HALF)) u_spi (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (x_start),
    .tx    (x_tx),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .done  (x_done),
    .rx    (x_rx)
  );

  eeld_seq #(
    .IMG_BYTES (IMG_BYTES),
    .ADDR_W    (ADDR_W),
    .EE_BASE   (EE_BASE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .x_done    (x_done),
    .x_rx      (x_rx),
    .x_start   (x_start),
    .x_tx      (x_tx),
    .cs_n      (spi_cs_n),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .done      (done),
    .busy      (busy),
    .res       (res)
  );

  assign cmp_err = res.cmp_err;
  assign sum_err = res.sum_err;
  assign fail_lo = res.fail_addr[7:0];
  assign fail_hi = res.fail_addr[15:8];
  assign irq     = res.cmp_err | res.sum_err;

endmodule

// File: rtl/eeld_autoload_chk.sv
module eeld_autoload_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic       busy,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       mem_we,
  input logic       mem_re,
  input logic       cmp_err,
  input logic       sum_err,
  input logic [7:0] fail_lo,
  input logic [7:0] fail_hi
);

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_cmp_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_err) |-> $past(mem_re, 2));

  p_clear_on_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!cmp_err && !sum_err && fail_lo == 8'h00 && fail_hi == 8'h00));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cmp_err) && $stable(sum_err) &&
                           $stable(fail_lo) && $stable(fail_hi)));

endmodule

bind eeld_autoload eeld_autoload_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .busy     (busy),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .cmp_err  (cmp_err),
  .sum_err  (sum_err),
  .fail_lo  (fail_lo),
  .fail_hi  (fail_hi)
);

// File: tb/eeld_autoload_tb_top.sv
module eeld_autoload_tb_top;

  localparam int          N    = 300;
  localparam int          AW   = 16;
  localparam logic [15:0] BASE = 16'h0100;
  localparam int          NVEC = 7;

  // {seed[41:34], bad_sum[33], restart[32], fault0[31:16], fault1[15:0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {8'h01, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF},
    {8'h02, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF},
    {8'h03, 1'b0, 1'b0, 16'h0005, 16'hFFFF},
    {8'h04, 1'b0, 1'b0, 16'h0122, 16'h010E},
    {8'h05, 1'b1, 1'b0, 16'h0000, 16'hFFFF},
    {8'h06, 1'b0, 1'b1, 16'h012B, 16'hFFFF},
    {8'h07, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, busy, spi_cs_n, spi_sclk, spi_mosi;
  logic          spi_miso = 1'b0;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = 8'h00;
  logic          cmp_err, sum_err, irq;
  logic [7:0]    fail_lo, fail_hi;

  always #5 clk = ~clk;

  eeld_autoload #(
    .IMG_BYTES (N),
    .ADDR_W    (AW),
    .EE_BASE   (BASE),
    .SCLK_HALF (1)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .busy      (busy),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .cmp_err   (cmp_err),
    .sum_err   (sum_err),
    .fail_lo   (fail_lo),
    .fail_hi   (fail_hi),
    .irq       (irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] img   [N];
  logic [7:0] mem_m [N];
  int fault0 = -1;
  int fault1 = -1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model: one-cycle read latency, optional stuck read faults
  always @(posedge clk) begin
    if (mem_we && mem_addr < N) mem_m[mem_addr] <= mem_wdata;
    if (mem_re) begin
      if (mem_addr < N)
        mem_rdata <= mem_m[mem_addr] ^
                     (((int'(mem_addr) == fault0) || (int'(mem_addr) == fault1)) ? 8'h10 : 8'h00);
      else
        mem_rdata <= 8'h00;
    end
  end

  // EEPROM model, mode 0, evaluated between clock edges
  int          ee_bits = 0;
  logic [23:0] ee_hdr = 24'h0;
  logic        sclk_q = 1'b0;
  logic        cs_q = 1'b1;
  int          frames = 0;
  int          hdr_bad = 0;

  always @(negedge clk) begin
    int k;
    int a;
    if (spi_cs_n === 1'b1) begin
      ee_bits = 0;
    end else if (spi_cs_n === 1'b0) begin
      if (spi_sclk && !sclk_q) begin
        if (ee_bits < 24) ee_hdr = {ee_hdr[22:0], spi_mosi};
        ee_bits++;
      end
      if (!spi_sclk && sclk_q && ee_bits >= 24) begin
        k = ee_bits - 24;
        a = int'(ee_hdr[15:0]) + k / 8 - int'(BASE);
        spi_miso = (a >= 0 && a < N) ? img[a][7 - (k % 8)] : 1'b0;
      end
    end
    if (spi_cs_n === 1'b1 && cs_q === 1'b0) begin
      frames++;
      if (ee_hdr != {8'h03, BASE}) hdr_bad++;
    end
    sclk_q = spi_sclk;
    cs_q   = spi_cs_n;
  end

  task automatic run_vec(input int v);
    logic [41:0] w;
    logic [7:0]  seed;
    logic [7:0]  s;
    bit          bad, rs, exp_cmp, timed_out;
    int          a0, a1, exp_addr, f0, h0, dones, post, cyc, busy_mid, memerr;
    w    = VEC[v];
    seed = w[41:34];
    bad  = w[33];
    rs   = w[32];
    a0   = int'(w[31:16]);
    a1   = int'(w[15:0]);
    s    = 8'h00;
    for (int j = 0; j < N - 1; j++) begin
      img[j] = seed * 8'd37 + 8'(j * 11) + 8'(j >> 3);
      s      = s + img[j];
    end
    img[N-1] = s + (bad ? 8'h01 : 8'h00);
    for (int j = 0; j < N; j++) mem_m[j] = ~img[j];
    fault0   = (a0 < N) ? a0 : -1;
    fault1   = (a1 < N) ? a1 : -1;
    exp_cmp  = (fault0 >= 0) || (fault1 >= 0);
    exp_addr = 0;
    if (fault0 >= 0 && (fault1 < 0 || fault0 < fault1)) exp_addr = fault0;
    else if (fault1 >= 0) exp_addr = fault1;
    f0 = frames;
    h0 = hdr_bad;
    dones = 0; post = 0; cyc = 0; busy_mid = 0; timed_out = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (post < 40 && !timed_out) begin
      @(negedge clk);
      cyc++;
      start = (rs && cyc == 200);
      if (cyc == 5) busy_mid = int'(busy);
      if (done) dones++;
      if (dones > 0) post++;
      if (cyc > 60000) timed_out = 1;
    end
    start = 1'b0;
    check(!timed_out, "R1 run finishes", cyc, 0);
    check(dones == 1, "R1 one done pulse per start", dones, 1);
    check(busy_mid == 1, "R1 busy during run", busy_mid, 1);
    check(busy == 1'b0, "R1 busy low after done", int'(busy), 0);
    check(frames - f0 == 2, "R6 two frames: load then verify", frames - f0, 2);
    check(hdr_bad - h0 == 0, "R3 R2 frame header 0x03 + base MSB first", hdr_bad - h0, 0);
    memerr = 0;
    for (int j = 0; j < N; j++) if (mem_m[j] !== img[j]) memerr++;
    check(memerr == 0, "R4 image written to memory", memerr, 0);
    check(sum_err == bad, "R5 checksum flag", int'(sum_err), int'(bad));
    check(cmp_err == exp_cmp, "R6 compare flag", int'(cmp_err), int'(exp_cmp));
    if (exp_cmp) begin
      check(fail_lo == 8'(exp_addr), "R7 first mismatch low byte", int'(fail_lo), exp_addr & 255);
      check(fail_hi == 8'(exp_addr >> 8), "R7 first mismatch high byte", int'(fail_hi), exp_addr >> 8);
    end else begin
      check({fail_hi, fail_lo} == 16'h0, "R8 capture cleared on start", int'({fail_hi, fail_lo}), 0);
    end
    check(irq == (bad || exp_cmp), "R8 irq from either flag", int'(irq), int'(bad || exp_cmp));
    if (rs) check(dones == 1 && frames - f0 == 2, "R10 start ignored while busy", dones, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(spi_cs_n == 1'b1, "R9 cs_n high", int'(spi_cs_n), 1);
    check(spi_sclk == 1'b0, "R9 sclk low", int'(spi_sclk), 0);
    check(!busy && !done, "R9 busy/done low", int'(busy) + int'(done), 0);
    check(!mem_we && !mem_re, "R9 memory strobes low", int'(mem_we) + int'(mem_re), 0);
    check(!irq && !cmp_err && !sum_err, "R9 flags clear", int'(irq), 0);
    check({fail_hi, fail_lo} == 16'h0, "R9 capture clear", int'({fail_hi, fail_lo}), 0);
    for (int v = 0; v < NVEC; v++) run_vec(v);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule